// File: doc/BRIEF.md
# Base-and-Bound Address Relocation Unit

This block turns program-relative word addresses into absolute memory addresses for the one job that is running. It covers two memory spaces. The main store has 18-bit addresses. The extended block-transfer store has 24-bit addresses. Each space has its own base register and its own length register. A request carries a relative address and a space select. If the relative address falls inside the window, the block adds the base and issues the absolute address. If it does not, the block issues nothing and raises a sticky fault flag.

The program always sees its first word as relative address 0. The supervisor loads the four window registers through a write port, and it clears the fault flag through a separate strobe. Setting the extended length to zero shuts that space off completely. A legacy input restricts main-store requests to a 17-bit range.

Top module: `reloc_unit`

## Requirements
- R1: A main-store request with relative address below the main length issues `abs_addr_o` = (main base + relative address) modulo 2^18, zero-extended to 24 bits. `vld_o` is high for exactly one cycle, in the cycle after the request.
- R2: A main-store request with relative address greater than or equal to the main length drives `vld_o` low in the next cycle and sets `err_o`.
- R3: An extended-store request (`sel_ext_i`=1) is checked against the extended length and relocated by the extended base, modulo 2^24. It does not use the main-store registers.
- R4: While the extended length is zero, every extended-store request faults and is not issued.
- R5: With `legacy_i`=1, a main-store request whose relative address bit 17 is set faults even when it lies below the main length. With `legacy_i`=0 the same request is issued. `legacy_i` has no effect on extended-store requests.
- R6: `err_o` stays high until a cycle with `sup_clr_err_i`=1 clears it. If a new fault arrives in the same cycle as the clear, `err_o` stays high.
- R7: A register is written only when `sup_we_i`=1. `sup_reg_i` selects the register: 0 = main base, 1 = main length, 2 = extended base, 3 = extended length. A main-store register keeps the low 18 bits of `sup_data_i`. A request in the same cycle as a write uses the value the register held before the write.
- R8: After reset, `vld_o`, `err_o` and `abs_addr_o` are zero and all four registers are zero, so every request faults until the lengths are loaded.
- R9: `abs_addr_o` keeps the last issued address through idle cycles and faulting requests.
- R10: A main-store request with any of relative address bits 23..18 set faults.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_i | input | 1 | Translation request strobe |
| sel_ext_i | input | 1 | 0 = main store, 1 = extended store |
| rel_addr_i | input | 24 | Program-relative word address |
| legacy_i | input | 1 | Restrict main-store requests to 17 bits |
| sup_we_i | input | 1 | Supervisor register write enable |
| sup_reg_i | input | 2 | Register select (0 main base, 1 main length, 2 ext base, 3 ext length) |
| sup_data_i | input | 24 | Supervisor write data |
| sup_clr_err_i | input | 1 | Clears the fault flag |
| abs_addr_o | output | 24 | Absolute address of the last issued request |
| vld_o | output | 1 | One-cycle strobe: an address was issued |
| err_o | output | 1 | Sticky fault flag |

## Verification
A corrupted length register shows up on the very next request near the window edge. Either a request that should be issued is refused, or an out-of-window access is let through, and the mismatch is visible one cycle after the request. A corrupted base register shows as a wrong `abs_addr_o` on the next issued request. A wrong fault flag persists because the flag is sticky, so it stays visible on every following cycle until the next clear. This makes it hard to miss even when later requests are legal.

// File: rtl/reloc_pkg.sv
package reloc_pkg;

  // Supervisor register select codes
  typedef enum logic [1:0] {
    SREG_MAIN_BASE = 2'd0,
    SREG_MAIN_LEN  = 2'd1,
    SREG_EXT_BASE  = 2'd2,
    SREG_EXT_LEN   = 2'd3
  } sreg_sel_e;

  // Space select on the request side
  typedef enum logic {
    SPACE_MAIN = 1'b0,
    SPACE_EXT  = 1'b1
  } space_e;

endpackage

// File: rtl/reloc_rst_sync.sv
module reloc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_sync_n = stage_q[1];

endmodule

// File: rtl/reloc_space.sv
module reloc_space #(
  parameter int AW         = 18,
  parameter int RELW       = 24,
  parameter bit TOPBIT_CHK = 1'b0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_base_i,
  input  logic            wr_len_i,
  input  logic [AW-1:0]   wr_data_i,
  input  logic [RELW-1:0] rel_i,
  input  logic            legacy_i,
  output logic [AW-1:0]   abs_o,
  output logic            ok_o
);

  logic [AW-1:0]   base_q, base_d;
  logic [AW-1:0]   len_q,  len_d;
  logic [RELW-1:0] len_w;
  logic            top_bad;

  // next-state: clock enables written out
  always_comb begin
    base_d = base_q;
    len_d  = len_q;
    if (wr_base_i) base_d = wr_data_i;
    if (wr_len_i)  len_d  = wr_data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      len_q  <= '0;
    end else begin
      base_q <= base_d;
      len_q  <= len_d;
    end
  end

  // bound check on the relative address, ahead of the adder
  always_comb begin
    len_w   = RELW'(len_q);
    top_bad = TOPBIT_CHK && legacy_i && rel_i[AW-1];
    ok_o    = (rel_i < len_w) && !top_bad;
    abs_o   = base_q + rel_i[AW-1:0];
  end

endmodule

// File: rtl/reloc_out.sv
module reloc_out #(
  parameter int XW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          sel_ext_i,
  input  logic          clr_i,
  input  logic          main_ok_i,
  input  logic [XW-1:0] main_abs_i,
  input  logic          ext_ok_i,
  input  logic [XW-1:0] ext_abs_i,
  output logic [XW-1:0] abs_o,
  output logic          vld_o,
  output logic          err_o
);

  logic [XW-1:0] abs_q, abs_d, pick_addr;
  logic          vld_q, vld_d, err_q, err_d;
  logic          pick_ok, issue, fault;

  always_comb begin
    pick_ok   = sel_ext_i ? ext_ok_i  : main_ok_i;
    pick_addr = sel_ext_i ? ext_abs_i : main_abs_i;
    issue     = req_i && pick_ok;
    fault     = req_i && !pick_ok;
    vld_d     = issue;
    err_d     = fault || (err_q && !clr_i);
    abs_d     = issue ? pick_addr : abs_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      abs_q <= '0;
      vld_q <= 1'b0;
      err_q <= 1'b0;
    end else begin
      abs_q <= abs_d;
      vld_q <= vld_d;
      err_q <= err_d;
    end
  end

  assign abs_o = abs_q;
  assign vld_o = vld_q;
  assign err_o = err_q;

endmodule

// File: rtl/reloc_unit.sv
module reloc_unit
  import reloc_pkg::*;
#(
  parameter int CM_AW = 18,
  parameter int XS_AW = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             sel_ext_i,
  input  logic [XS_AW-1:0] rel_addr_i,
  input  logic             legacy_i,
  input  logic             sup_we_i,
  input  logic [1:0]       sup_reg_i,
  input  logic [XS_AW-1:0] sup_data_i,
  input  logic             sup_clr_err_i,
  output logic [XS_AW-1:0] abs_addr_o,
  output logic             vld_o,
  output logic             err_o
);

  logic             rst_int_n;
  logic             wr_mb, wr_ml, wr_eb, wr_el;
  logic [CM_AW-1:0] main_abs;
  logic [XS_AW-1:0] main_abs_w;
  logic [XS_AW-1:0] ext_abs;
  logic             main_ok, ext_ok;

  reloc_rst_sync i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  always_comb begin
    wr_mb = sup_we_i && (sreg_sel_e'(sup_reg_i) == SREG_MAIN_BASE);
    wr_ml = sup_we_i && (sreg_sel_e'(sup_reg_i) == SREG_MAIN_LEN);
    wr_eb = sup_we_i && (sreg_sel_e'(sup_reg_i) == SREG_EXT_BASE);
    wr_el = sup_we_i && (sreg_sel_e'(sup_reg_i) == SREG_EXT_LEN);
  end

  reloc_space #(.AW(CM_AW), .RELW(XS_AW), .TOPBIT_CHK(1'b1)) i_main (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_base_i (wr_mb),
    .wr_len_i  (wr_ml),
    .wr_data_i (sup_data_i[CM_AW-1:0]),
    .rel_i     (rel_addr_i),
    .legacy_i  (legacy_i),
    .abs_o     (main_abs),
    .ok_o      (main_ok)
  );

  reloc_space #(.AW(XS_AW), .RELW(XS_AW), .TOPBIT_CHK(1'b0)) i_ext (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_base_i (wr_eb),
    .wr_len_i  (wr_el),
    .wr_data_i (sup_data_i),
    .rel_i     (rel_addr_i),
    .legacy_i  (legacy_i),
    .abs_o     (ext_abs),
    .ok_o      (ext_ok)
  );

  assign main_abs_w = XS_AW'(main_abs);

  reloc_out #(.XW(XS_AW)) i_out (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .req_i      (req_i),
    .sel_ext_i  (sel_ext_i),
    .clr_i      (sup_clr_err_i),
    .main_ok_i  (main_ok),
    .main_abs_i (main_abs_w),
    .ext_ok_i   (ext_ok),
    .ext_abs_i  (ext_abs),
    .abs_o      (abs_addr_o),
    .vld_o      (vld_o),
    .err_o      (err_o)
  );

endmodule

// File: rtl/reloc_unit_chk.sv
module reloc_unit_chk #(
  parameter int CM_AW = 18,
  parameter int XS_AW = 24
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_i,
  input logic             sel_ext_i,
  input logic [XS_AW-1:0] rel_addr_i,
  input logic             legacy_i,
  input logic             sup_we_i,
  input logic [1:0]       sup_reg_i,
  input logic [XS_AW-1:0] sup_data_i,
  input logic             sup_clr_err_i,
  input logic [XS_AW-1:0] abs_addr_o,
  input logic             vld_o,
  input logic             err_o
);

  // shadow of the extended length, observed at the write port
  logic [XS_AW-1:0] ext_len_sh;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_len_sh <= '0;
    else if (sup_we_i && sup_reg_i == 2'd3) ext_len_sh <= sup_data_i;
  end

  // R1
  vld_after_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vld_o |-> $past(req_i));

  // R1
  main_abs_narrow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (vld_o && !$past(sel_ext_i)) |-> (abs_addr_o[XS_AW-1:CM_AW] == '0));

  // R6
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_o && !sup_clr_err_i) |=> err_o);

  // R2
  err_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_o) |-> $past(req_i));

  // R4
  ext_zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && sel_ext_i && ext_len_sh == '0) |=> (!vld_o && err_o));

  // R5
  legacy_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !sel_ext_i && legacy_i && rel_addr_i[CM_AW-1]) |=> (!vld_o && err_o));

endmodule

bind reloc_unit reloc_unit_chk #(.CM_AW(CM_AW), .XS_AW(XS_AW)) i_reloc_unit_chk (.*);

// File: tb/test_reloc_unit.sv
module test_reloc_unit;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_i, sel_ext_i, legacy_i, sup_we_i, sup_clr_err_i;
  logic [23:0] rel_addr_i, sup_data_i;
  logic [1:0]  sup_reg_i;
  logic [23:0] abs_addr_o;
  logic        vld_o, err_o;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic        vld;
    logic        err;
    logic [23:0] addr;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  // bench reference state
  logic [17:0] m_mbase, m_mlen;
  logic [23:0] m_ebase, m_elen, m_addr;
  logic        m_err;

  always #(CLK_PERIOD/2) clk = ~clk;

  reloc_unit i_reloc_unit (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .sel_ext_i(sel_ext_i),
    .rel_addr_i(rel_addr_i), .legacy_i(legacy_i), .sup_we_i(sup_we_i),
    .sup_reg_i(sup_reg_i), .sup_data_i(sup_data_i), .sup_clr_err_i(sup_clr_err_i),
    .abs_addr_o(abs_addr_o), .vld_o(vld_o), .err_o(err_o)
  );

  task automatic check(input string tag, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one driven cycle: compute expected from the bench model, then push it
  task automatic cyc(input logic rq, input logic sel, input logic [23:0] rel, input logic lg,
                     input logic we, input logic [1:0] rs, input logic [23:0] wd,
                     input logic clr, input string tag);
    logic ok;
    logic [23:0] a;
    exp_t e;
    @(negedge clk);
    req_i = rq; sel_ext_i = sel; rel_addr_i = rel; legacy_i = lg;
    sup_we_i = we; sup_reg_i = rs; sup_data_i = wd; sup_clr_err_i = clr;
    if (sel) begin
      ok = rel < m_elen;
      a  = m_ebase + rel;
    end else begin
      ok = (rel < {6'd0, m_mlen}) && !(lg && rel[17]);
      a  = {6'd0, 18'(m_mbase + rel[17:0])};
    end
    m_err = (rq && !ok) || (m_err && !clr);
    if (rq && ok) m_addr = a;
    e.vld = rq && ok; e.err = m_err; e.addr = m_addr; e.tag = tag;
    exp_q.push_back(e);
    if (we) begin
      case (rs)
        2'd0: m_mbase = wd[17:0];
        2'd1: m_mlen  = wd[17:0];
        2'd2: m_ebase = wd;
        default: m_elen = wd;
      endcase
    end
  endtask

  task automatic req_m(input logic [23:0] rel, input logic lg, input string tag);
    cyc(1'b1, 1'b0, rel, lg, 1'b0, 2'd0, 24'd0, 1'b0, tag);
  endtask
  task automatic req_e(input logic [23:0] rel, input string tag);
    cyc(1'b1, 1'b1, rel, 1'b0, 1'b0, 2'd0, 24'd0, 1'b0, tag);
  endtask
  task automatic wr(input logic [1:0] rs, input logic [23:0] wd, input string tag);
    cyc(1'b0, 1'b0, 24'd0, 1'b0, 1'b1, rs, wd, 1'b0, tag);
  endtask
  task automatic clr_err(input string tag);
    cyc(1'b0, 1'b0, 24'd0, 1'b0, 1'b0, 2'd0, 24'd0, 1'b1, tag);
  endtask
  task automatic idle(input string tag);
    cyc(1'b0, 1'b0, 24'd0, 1'b0, 1'b0, 2'd0, 24'd0, 1'b0, tag);
  endtask

  // monitor: pops one expected item per clock edge
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check({e.tag, " vld"},  {23'd0, vld_o}, {23'd0, e.vld});
      check({e.tag, " err"},  {23'd0, err_o}, {23'd0, e.err});
      check({e.tag, " addr"}, abs_addr_o, e.addr);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    req_i = 0; sel_ext_i = 0; rel_addr_i = 0; legacy_i = 0;
    sup_we_i = 0; sup_reg_i = 0; sup_data_i = 0; sup_clr_err_i = 0;
    m_mbase = 0; m_mlen = 0; m_ebase = 0; m_elen = 0; m_addr = 0; m_err = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R8 reset state
    check("R8 reset vld",  {23'd0, vld_o}, 24'd0);
    check("R8 reset err",  {23'd0, err_o}, 24'd0);
    check("R8 reset addr", abs_addr_o, 24'd0);

    req_m(24'd0, 1'b0, "R8 zero length main");
    req_e(24'd0, "R8 zero length ext");
    idle("R6 sticky idle");
    clr_err("R6 clear");
    idle("R6 after clear");

    // R7: no write without enable
    cyc(1'b0, 1'b0, 24'd0, 1'b0, 1'b0, 2'd1, 24'h000040, 1'b0, "R7 no enable");
    req_m(24'd0, 1'b0, "R7 len still zero");
    clr_err("R6 clear");
    wr(2'd0, 24'h000100, "R7 write base");
    wr(2'd1, 24'hFF0040, "R7 write len low bits");
    req_m(24'd0, 1'b0, "R1 first word");
    req_m(24'h00003F, 1'b0, "R1 last word");
    req_m(24'h000040, 1'b0, "R2 at length");
    idle("R9 hold after fault");
    req_m(24'h000041, 1'b0, "R2 beyond length");
    clr_err("R6 clear");
    // R6 fault in same cycle as clear
    cyc(1'b1, 1'b0, 24'h000050, 1'b0, 1'b0, 2'd0, 24'd0, 1'b1, "R6 fault wins clear");
    clr_err("R6 clear");
    // R7 same-cycle write and request uses old base
    cyc(1'b1, 1'b0, 24'h000010, 1'b0, 1'b1, 2'd0, 24'h03FFF0, 1'b0, "R7 old base used");
    wr(2'd1, 24'h000100, "R7 write len");
    req_m(24'h000020, 1'b0, "R1 wrap modulo");
    idle("R9 hold idle");
    // R5 legacy mode
    wr(2'd0, 24'h000000, "R7 base zero");
    wr(2'd1, 24'h03FFFF, "R7 len max");
    req_m(24'h020000, 1'b1, "R5 legacy top bit");
    clr_err("R6 clear");
    req_m(24'h020000, 1'b0, "R5 normal top bit");
    req_m(24'h01FFFF, 1'b1, "R5 legacy low range");
    req_m(24'h040000, 1'b0, "R10 high bits");
    clr_err("R6 clear");
    // R3 / R4 extended store
    req_e(24'h000000, "R4 ext zero len");
    clr_err("R6 clear");
    wr(2'd2, 24'hF00000, "R7 ext base");
    req_e(24'h000005, "R4 ext still zero len");
    wr(2'd3, 24'h001000, "R7 ext len");
    req_e(24'h000FFF, "R3 ext last word");
    req_e(24'h001000, "R3 ext at length");
    clr_err("R6 clear");
    cyc(1'b1, 1'b1, 24'h000000, 1'b1, 1'b0, 2'd0, 24'd0, 1'b0, "R5 legacy ignored ext");
    wr(2'd0, 24'h000200, "R7 main base");
    req_e(24'h000010, "R3 ext independent of main");
    wr(2'd2, 24'hFFFFF0, "R7 ext base high");
    req_e(24'h000020, "R3 ext wrap");
    req_m(24'h000001, 1'b0, "R1 main after ext");
    wr(2'd3, 24'h000000, "R7 ext len zero");
    req_e(24'h000001, "R4 ext disabled again");
    idle("R6 final");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule